// File: doc/BRIEF.md
# Thirteen-Level Staircase Gate Generator

This block drives the ten power switches of a single-phase staircase inverter that produces thirteen output levels, from minus six to plus six units. A level stage built from three complementary switch pairs stacks unequal DC sources to form the magnitude, and a four-switch H-bridge picks the sign. A free-running phase accumulator sweeps one fundamental period. Within every quarter of that period, the folded phase is compared against six programmable step angles. The number of angles already passed is the magnitude. The half of the period the accumulator is in decides the sign.

The step angles come from an offline harmonic-elimination solver and reach the block as six unsigned phase words. A full turn maps to 2^16 counts. The block samples the angle words only at the start of a period, or while it is idle, so a change never reshapes a half-wave in progress. The increment word sets the output frequency. The signed level and the gate vector leave from one register stage, so they always describe the same instant.

Top module: `ml_gate_gen`

## Requirements
- R1: The signed level output stays within -6..+6. Its magnitude equals the number of the six active angles that are less than or equal to the folded phase q.
- R2: With acc the 16-bit accumulator and h = acc mod 32768, the folded phase is q = h when h < 16384 and q = 32768 - h otherwise. This mirrors each half-wave about its midpoint.
- R3: When acc bit 15 is 1 (second half of the period), the level is the negative of the magnitude. Otherwise it is positive.
- R4: The gate vector is gate_o[0..5] = S1..S6, gate_o[6] = H1, gate_o[7] = H2, gate_o[8] = H3, gate_o[9] = H4. For magnitudes 1 to 6, S1..S6 read 011001, 011010, 010110, 101001, 101010 and 100110.
- R5: At every nonzero level, S1/S2, S3/S4 and S5/S6 are complementary. At level 0 all six level switches are low.
- R6: A positive level drives only H1 and H4. A negative level drives only H2 and H3. Level 0 drives only H1 and H3 in the first half-period and only H2 and H4 in the second.
- R7: When two angles are equal, the magnitude steps over the skipped value. With the first two angles equal, magnitude 1 never appears.
- R8: The active angles are reloaded from angles_i only while reset or disabled, and on the enabled cycle where the accumulator wraps past 2^16. A change at any other time has no effect on the output until the next wrap.
- R9: During reset or while en_i is low, the output is level 0 with only H1 and H3 high (gate_o = 0x140) from the following edge on, and the accumulator restarts from 0.
- R10: The outputs are registered. The values seen after an edge are computed from the accumulator and active angles as they stood before that edge.
- R11: On each enabled cycle the accumulator advances by inc_i modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable; low forces the idle zero state |
| inc_i | input | 16 | Phase increment per cycle |
| angles_i | input | 96 | Six 16-bit step angles, angle k in bits [16k+15:16k] |
| gate_o | output | 10 | Gate drives S1..S6, H1..H4 |
| lvl_o | output | 4 | Signed output level, two's complement |

## Verification
On every cycle the assertions check the properties that hold at any single instant: the level stays in range, the pairs are complementary or all low, the H-bridge pattern matches the sign with no shoot-through leg, and disable leads to the idle state on the next edge. Only the bench scenarios can show the time behaviour. These are the exact step positions against the folded phase, the mirroring about the quarter point, the merged step from equal angles, and the deferral of angle changes to the period wrap. The bench compares every output cycle against a model built from R1 to R11, across several increments and angle sets.

// File: rtl/mlg_pkg.sv
package mlg_pkg;

    localparam int N_ANG   = 6;
    localparam int LVL_W   = 4;
    localparam int MAG_W   = 3;

    typedef struct packed {
        logic [3:0] hb;   // [0]=H1 [1]=H2 [2]=H3 [3]=H4
        logic [5:0] sw;   // [0]=S1 ... [5]=S6
    } gate_t;

    typedef enum logic [1:0] {
        HB_ZERO_POS = 2'd0,
        HB_ZERO_NEG = 2'd1,
        HB_DRIVE_POS = 2'd2,
        HB_DRIVE_NEG = 2'd3
    } hb_mode_e;

    // Level-stage switch pattern, bit 0 is S1
    function automatic logic [5:0] sw_pattern(input logic [MAG_W-1:0] mag);
        logic [5:0] p;
        case (mag)
            3'd1:    p = 6'b100110;
            3'd2:    p = 6'b010110;
            3'd3:    p = 6'b011010;
            3'd4:    p = 6'b100101;
            3'd5:    p = 6'b010101;
            3'd6:    p = 6'b011001;
            default: p = 6'b000000;
        endcase
        return p;
    endfunction

    function automatic logic [3:0] hb_pattern(input hb_mode_e m);
        logic [3:0] p;
        case (m)
            HB_ZERO_POS:  p = 4'b0101;
            HB_ZERO_NEG:  p = 4'b1010;
            HB_DRIVE_POS: p = 4'b1001;
            default:      p = 4'b0110;
        endcase
        return p;
    endfunction

    function automatic gate_t build_gates(input logic [MAG_W-1:0] mag, input logic neg);
        gate_t g;
        hb_mode_e m;
        if (mag == '0) m = neg ? HB_ZERO_NEG : HB_ZERO_POS;
        else           m = neg ? HB_DRIVE_NEG : HB_DRIVE_POS;
        g.sw = sw_pattern(mag);
        g.hb = hb_pattern(m);
        return g;
    endfunction

endpackage

// File: rtl/mlg_phase_acc.sv
module mlg_phase_acc #(
    parameter int PHASE_W = 16
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               en_i,
    input  logic [PHASE_W-1:0] inc_i,
    output logic [PHASE_W-1:0] acc_o,
    output logic               wrap_o
);
    logic [PHASE_W:0] sum;

    assign sum    = {1'b0, acc_o} + {1'b0, inc_i};
    assign wrap_o = en_i & sum[PHASE_W];

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) acc_o <= '0;
        else                acc_o <= sum[PHASE_W-1:0];
    end
endmodule

// File: rtl/mlg_angle_bank.sv
module mlg_angle_bank #(
    parameter int PHASE_W = 16,
    parameter int N       = 6
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 en_i,
    input  logic                 wrap_i,
    input  logic [N*PHASE_W-1:0] angles_i,
    output logic [N*PHASE_W-1:0] active_o
);
    logic load;
    assign load = rst_i | ~en_i | wrap_i;

    for (genvar k = 0; k < N; k++) begin : g_slot
        always_ff @(posedge clk_i) begin
            if (load) active_o[k*PHASE_W +: PHASE_W] <= angles_i[k*PHASE_W +: PHASE_W];
        end
    end
endmodule

// File: rtl/mlg_level_cmp.sv
module mlg_level_cmp
    import mlg_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic [PHASE_W-1:0]       acc_i,
    input  logic [N_ANG*PHASE_W-1:0] active_i,
    output logic [MAG_W-1:0]         mag_o,
    output logic                     neg_o
);
    localparam int H_W = PHASE_W - 1;
    localparam logic [PHASE_W-1:0] QUARTER = PHASE_W'(1) << (PHASE_W - 2);
    localparam logic [PHASE_W-1:0] HALF    = PHASE_W'(1) << (PHASE_W - 1);

    logic [PHASE_W-1:0] half_pos;
    logic [PHASE_W-1:0] folded;
    logic [N_ANG-1:0]   passed;

    assign neg_o    = acc_i[PHASE_W-1];
    assign half_pos = {1'b0, acc_i[H_W-1:0]};
    assign folded   = (half_pos < QUARTER) ? half_pos : (HALF - half_pos);

    for (genvar k = 0; k < N_ANG; k++) begin : g_cmp
        assign passed[k] = folded >= active_i[k*PHASE_W +: PHASE_W];
    end

    always_comb begin
        mag_o = '0;
        for (int k = 0; k < N_ANG; k++) mag_o = mag_o + MAG_W'(passed[k]);
    end
endmodule

// File: rtl/mlg_gate_map.sv
module mlg_gate_map
    import mlg_pkg::*;
(
    input  logic                    clk_i,
    input  logic                    rst_i,
    input  logic                    en_i,
    input  logic [MAG_W-1:0]        mag_i,
    input  logic                    neg_i,
    output gate_t                   gate_o,
    output logic signed [LVL_W-1:0] lvl_o
);
    logic signed [LVL_W-1:0] lvl_d;
    assign lvl_d = neg_i ? -$signed({1'b0, mag_i}) : $signed({1'b0, mag_i});

    always_ff @(posedge clk_i) begin
        if (rst_i || !en_i) begin
            gate_o <= build_gates('0, 1'b0);
            lvl_o  <= '0;
        end else begin
            gate_o <= build_gates(mag_i, neg_i);
            lvl_o  <= lvl_d;
        end
    end
endmodule

// File: rtl/ml_gate_gen.sv
module ml_gate_gen
    import mlg_pkg::*;
#(
    parameter int PHASE_W = 16
) (
    input  logic                       clk_i,
    input  logic                       rst_i,
    input  logic                       en_i,
    input  logic [PHASE_W-1:0]         inc_i,
    input  logic [N_ANG*PHASE_W-1:0]   angles_i,
    output logic [9:0]                 gate_o,
    output logic signed [LVL_W-1:0]    lvl_o
);
    logic [PHASE_W-1:0]       acc;
    logic                     wrap;
    logic [N_ANG*PHASE_W-1:0] active;
    logic [MAG_W-1:0]         mag;
    logic                     neg;
    gate_t                    gates;

    mlg_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .inc_i(inc_i),
        .acc_o(acc), .wrap_o(wrap)
    );

    mlg_angle_bank #(.PHASE_W(PHASE_W), .N(N_ANG)) u_bank (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .wrap_i(wrap),
        .angles_i(angles_i), .active_o(active)
    );

    mlg_level_cmp #(.PHASE_W(PHASE_W)) u_cmp (
        .acc_i(acc), .active_i(active), .mag_o(mag), .neg_o(neg)
    );

    mlg_gate_map u_map (
        .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .mag_i(mag), .neg_i(neg),
        .gate_o(gates), .lvl_o(lvl_o)
    );

    assign gate_o = gates;
endmodule

// File: rtl/mlg_checker.sv
module mlg_checker (
    input logic              clk_i,
    input logic              rst_i,
    input logic              en_i,
    input logic [9:0]        gate_o,
    input logic signed [3:0] lvl_o
);
    assert_level_range_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_o >= -4'sd6) && (lvl_o <= 4'sd6));

    assert_pairs_complementary_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_o != 0) |-> ((gate_o[0] ^ gate_o[1]) && (gate_o[2] ^ gate_o[3]) && (gate_o[4] ^ gate_o[5])));

    assert_zero_state_low_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_o == 0) |-> (gate_o[5:0] == 6'b0));

    assert_positive_bridge_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_o > 0) |-> (gate_o[9:6] == 4'b1001));

    assert_negative_bridge_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (lvl_o < 0) |-> (gate_o[9:6] == 4'b0110));

    assert_no_shoot_through_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        !(gate_o[6] && gate_o[7]) && !(gate_o[8] && gate_o[9]) && ($countones(gate_o[9:6]) == 2));

    assert_disable_idle_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        !en_i |=> ((lvl_o == 0) && (gate_o == 10'h140)));
endmodule

bind ml_gate_gen mlg_checker u_chk (
    .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .gate_o(gate_o), .lvl_o(lvl_o)
);

// File: tb/sim_ml_gate_gen.sv
module sim_ml_gate_gen;
    logic              clk = 1'b0;
    logic              rst;
    logic              en;
    logic [15:0]       inc;
    logic [95:0]       angles;
    logic [9:0]        gate;
    logic signed [3:0] lvl;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_on = 0;
    bit seen_one = 0;
    bit seen_p6 = 0;
    bit seen_n6 = 0;

    always #2.5 clk = ~clk;

    ml_gate_gen u0 (.clk_i(clk), .rst_i(rst), .en_i(en), .inc_i(inc),
                    .angles_i(angles), .gate_o(gate), .lvl_o(lvl));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Reference model from the requirements
    logic [15:0] m_acc;
    logic [95:0] m_ang;
    int          e_lvl;
    logic [9:0]  e_gate;

    function automatic int ref_level(input logic [15:0] a, input logic [95:0] an);
        int h, q, n;
        h = a % 32768;
        q = (h < 16384) ? h : 32768 - h;
        n = 0;
        for (int k = 0; k < 6; k++) if (q >= int'(an[k*16 +: 16])) n++;
        return a[15] ? -n : n;
    endfunction

    function automatic logic [9:0] ref_gates(input int l, input bit neg);
        logic [5:0] s;  // written S1..S6 left to right
        logic [9:0] g;
        int m;
        m = (l < 0) ? -l : l;
        case (m)
            1: s = 6'b011001;
            2: s = 6'b011010;
            3: s = 6'b010110;
            4: s = 6'b101001;
            5: s = 6'b101010;
            6: s = 6'b100110;
            default: s = 6'b000000;
        endcase
        g = '0;
        for (int k = 0; k < 6; k++) g[k] = s[5-k];
        if (l > 0)      begin g[6] = 1; g[9] = 1; end
        else if (l < 0) begin g[7] = 1; g[8] = 1; end
        else if (!neg)  begin g[6] = 1; g[8] = 1; end
        else            begin g[7] = 1; g[9] = 1; end
        return g;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst || !en) begin
            m_acc  <= 16'd0;
            m_ang  <= angles;
            e_lvl  <= 0;
            e_gate <= 10'h140;
        end else begin
            e_lvl  <= ref_level(m_acc, m_ang);
            e_gate <= ref_gates(ref_level(m_acc, m_ang), m_acc[15]);
            m_acc  <= m_acc + inc;
            if ({1'b0, m_acc} + {1'b0, inc} > 17'hFFFF) m_ang <= angles;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            check(int'(lvl) == e_lvl, "R1 R2 R3 R11 level", int'(lvl), e_lvl);
            check(gate == e_gate, "R4 R5 R6 R10 gates", int'(gate), int'(e_gate));
            if (lvl == 1 || lvl == -1) seen_one = 1;
            if (lvl == 6)  seen_p6 = 1;
            if (lvl == -6) seen_n6 = 1;
        end
    end

    function automatic logic [95:0] pack6(input int a0, a1, a2, a3, a4, a5);
        return {16'(a5), 16'(a4), 16'(a3), 16'(a2), 16'(a1), 16'(a0)};
    endfunction

    task automatic run(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic signed [3:0] held;
        rst = 1; en = 0; inc = 16'd7;
        angles = pack6(1857, 1857, 4345, 6681, 8374, 12033);
        run(4);
        check(lvl == 0, "R9 reset level", int'(lvl), 0);
        check(gate == 10'h140, "R9 reset gates", int'(gate), 'h140);
        rst = 0; en = 1;
        cmp_on = 1;
        run(18800);                          // two periods, default angles
        check(!seen_one, "R7 no magnitude 1 with equal angles", seen_one, 0);
        check(seen_p6 && seen_n6, "R3 both polarities reach 6", seen_p6 + seen_n6, 2);

        // R8: freeze phase, change angles, output must hold
        inc = 16'd0;
        run(2);
        held = lvl;
        angles = pack6(16000, 16000, 16000, 16000, 16000, 16000);
        run(20);
        check(lvl == held, "R8 angles deferred until wrap", int'(lvl), int'(held));

        // distinct angles, faster sweep
        angles = pack6(1000, 3000, 5000, 9000, 12000, 15000);
        inc = 16'd113;
        run(2000);

        // mid-period angle change, then wraps
        run(137);
        angles = pack6(500, 2500, 2600, 7000, 14000, 16384);
        inc = 16'd251;
        run(800);

        // R9: disable mid-run
        en = 0;
        run(1);
        check(lvl == 0 && gate == 10'h140, "R9 disable idle", int'(gate), 'h140);
        run(3);
        en = 1;
        run(1);
        check(lvl == 0, "R9 restart from phase 0", int'(lvl), 0);

        // all angles zero, half-turn increment: alternate +6 / -6
        angles = pack6(0, 0, 0, 0, 0, 0);
        en = 0; run(2); en = 1; inc = 16'h8000;
        run(3);
        check(lvl == 6 || lvl == -6, "R1 full magnitude at zero angles", int'(lvl), 6);
        run(40);

        cmp_on = 0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule